// File: doc/BRIEF.md
# Chained Buffer Copy-Out Engine

This block copies one completed packet out of a shared packet buffer into a contiguous destination region. The packet sits in a chain of fixed-size buffering units. Every unit holds data words followed by one link word, and that link word names the next unit of the chain. The host programs a transfer with three values: the tag of the first unit, the packet length in bytes and a destination base word address. The engine then walks the chain by itself. It reads the buffer through a 16-bit random-access port in page-mode bursts, follows each link word and writes the data words to the destination at addresses that go up by one for each word.

When the engine has finished reading a unit, it hands that unit's tag back to the free pool. The receive side has priority on the buffer port, so the port can refuse a read request in any cycle. While a request is refused, the engine holds the request with its address unchanged and makes no progress. A one-cycle done pulse closes the transfer after the last destination write and the last tag return.

Top module: `chain_copy_engine`

## Requirements
- R1: After reset, busy_o, done_o, rd_req_o, rd_first_o, dst_we_o and free_vld_o are all low.
- R2: A go_i pulse while idle loads start_tag_i, len_i and dst_base_i, and busy_o rises in the next cycle.
- R3: The buffer word address is {unit tag, word offset}, with a 3-bit offset for the default 8-word unit. Data words sit at offsets 0 to 6, and read data returns in the cycle after a granted request. The packet occupies ceil(len/2) words. These words are written in chain order to dst_base_i, dst_base_i+1 and so on, one write per word.
- R4: After the data word at offset 6, the engine reads the link word at offset 7. The low 5 bits of the link word are the tag of the next unit.
- R5: Each unit the packet occupies is reported exactly once on free_tag_o with a free_vld_o pulse, in chain order. The final unit is reported as well.
- R6: The link word of the final unit is never read. The granted read count is therefore words + units - 1.
- R7: While rd_req_o is high and rd_gnt_i is low, rd_req_o stays high and rd_addr_o stays unchanged in the next cycle. Refused cycles do not change the copied data or the returned tags.
- R8: rd_first_o marks the read that opens a page burst: the first read of each unit and the first read after a refused request. In a transfer with no refusals, exactly one granted read per unit carries it.
- R9: done_o is a one-cycle pulse that comes exactly one cycle after the later of the last destination write and the last free_vld_o pulse. busy_o is low in that same cycle.
- R10: A go_i pulse while busy is ignored. The running transfer completes unchanged and produces only one done_o pulse.
- R11: A zero length makes no buffer reads and no destination writes. It still returns the start tag and pulses done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start pulse |
| start_tag_i | input | 5 | Tag of the first unit of the packet |
| len_i | input | 12 | Packet length in bytes |
| dst_base_i | input | 12 | First destination word address |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| rd_req_o | output | 1 | Buffer read request |
| rd_first_o | output | 1 | Request opens a page burst |
| rd_addr_o | output | 8 | Buffer word address |
| rd_gnt_i | input | 1 | Read request accepted this cycle |
| rd_data_i | input | 16 | Read data, valid one cycle after a grant |
| dst_we_o | output | 1 | Destination write strobe |
| dst_addr_o | output | 12 | Destination word address |
| dst_data_o | output | 16 | Destination write data |
| free_vld_o | output | 1 | Freed tag valid |
| free_tag_o | output | 5 | Freed unit tag |

## Verification
The bench aims at the length boundaries.

- A packet that ends exactly on the last data word of a unit shows whether the final link is fetched anyway. A design that fetches it makes an extra read and follows a stray chain.
- A packet that spills a single word into a new unit shows whether the link is followed at all.
- An odd byte count shows whether the word count rounds up.
- A zero length shows whether the start tag is still freed.

Grant patterns that refuse one cycle in three, and two in four, expose the stall faults. An engine that moves its address or counters on a refused cycle would skip or duplicate words. A burst marker that is not raised again after a refusal would let the memory side reuse a closed page. A go pulse in the middle of a transfer catches a design that reloads its registers while busy.

// File: rtl/cce_pkg.sv
package cce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_LNK,
    ST_FIN,
    ST_DONE
  } cce_state_e;
endpackage

// File: rtl/cce_burst.sv
module cce_burst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic new_unit_i,
  input  logic req_i,
  input  logic gnt_i,
  output logic first_o
);
  logic first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                first_q <= 1'b0;
    else if (new_unit_i)        first_q <= 1'b1;
    else if (req_i && gnt_i)    first_q <= 1'b0;
    else if (req_i && !gnt_i)   first_q <= 1'b1;  // page lost while refused
  end

  assign first_o = req_i & first_q;

  // R8
  reopen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !gnt_i |=> !req_i || first_o);
endmodule

// File: rtl/cce_sink.sv
module cce_sink #(
  parameter int DATA_W = 16,
  parameter int DST_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DST_W-1:0]  base_i,
  input  logic              word_vld_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              we_o,
  output logic [DST_W-1:0]  addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DST_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= word_vld_i;
      if (load_i) begin
        ptr_q <= base_i;
      end else if (word_vld_i) begin
        addr_o <= ptr_q;
        data_o <= word_i;
        ptr_q  <= ptr_q + DST_W'(1);
      end
    end
  end

  // R3
  dst_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o || addr_o == $past(addr_o) + DST_W'(1));
endmodule

// File: rtl/cce_walker.sv
module cce_walker
  import cce_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int UNIT_WORDS = 8,
  parameter int TAG_W      = 5,
  parameter int LEN_W      = 12,
  localparam int IDX_W     = $clog2(UNIT_WORDS),
  localparam int ADDR_W    = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [TAG_W-1:0]  start_tag_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              load_o,
  output logic              new_unit_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              word_vld_o,
  output logic              free_vld_o,
  output logic [TAG_W-1:0]  free_tag_o
);
  localparam logic [IDX_W-1:0] LNK_IDX = IDX_W'(UNIT_WORDS - 1);

  cce_state_e       state_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] rem_q;
  logic             ret_q, ret_lnk_q;
  logic [LEN_W:0]   len_p1;
  logic [LEN_W-1:0] words;
  logic             go_ok, is_lnk, lnk_back;

  assign len_p1   = {1'b0, len_i} + (LEN_W+1)'(1);
  assign words    = len_p1[LEN_W:1];
  assign go_ok    = go_i && (state_q == ST_IDLE);
  assign is_lnk   = (idx_q == LNK_IDX);
  assign lnk_back = (state_q == ST_LNK) && ret_q && ret_lnk_q;

  assign rd_req_o   = (state_q == ST_RD);
  assign rd_addr_o  = {tag_q, idx_q};
  assign busy_o     = (state_q != ST_IDLE);
  assign load_o     = go_ok;
  assign new_unit_o = go_ok || lnk_back;
  assign word_vld_o = ret_q && !ret_lnk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tag_q      <= '0;
      idx_q      <= '0;
      rem_q      <= '0;
      ret_q      <= 1'b0;
      ret_lnk_q  <= 1'b0;
      free_vld_o <= 1'b0;
      free_tag_o <= '0;
      done_o     <= 1'b0;
    end else begin
      free_vld_o <= 1'b0;
      done_o     <= 1'b0;
      ret_q      <= rd_req_o && rd_gnt_i;
      ret_lnk_q  <= rd_req_o && rd_gnt_i && is_lnk;
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          tag_q   <= start_tag_i;
          idx_q   <= '0;
          rem_q   <= words;
          state_q <= (words == '0) ? ST_FIN : ST_RD;
        end
        ST_RD: if (rd_gnt_i) begin
          if (is_lnk) begin
            state_q <= ST_LNK;
          end else begin
            rem_q <= rem_q - LEN_W'(1);
            if (rem_q == LEN_W'(1)) state_q <= ST_FIN;
            else                    idx_q   <= idx_q + IDX_W'(1);
          end
        end
        ST_LNK: if (lnk_back) begin
          free_vld_o <= 1'b1;
          free_tag_o <= tag_q;
          tag_q      <= rd_data_i[TAG_W-1:0];
          idx_q      <= '0;
          state_q    <= ST_RD;
        end
        ST_FIN: begin
          free_vld_o <= 1'b1;
          free_tag_o <= tag_q;
          state_q    <= ST_DONE;
        end
        ST_DONE: begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_gnt_i |=> rd_req_o && $stable(rd_addr_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  no_tail_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && is_lnk |-> rem_q != '0);
  // R5
  free_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_vld_o |-> busy_o);
  // R10
  go_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && busy_o && !done_o |=> $stable(rd_addr_o) || rd_req_o || busy_o);
endmodule

// File: rtl/chain_copy_engine.sv
module chain_copy_engine #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 8,
  parameter int UNIT_WORDS = 8,
  parameter int LEN_W      = 12,
  parameter int DST_W      = 12,
  localparam int TAG_W     = ADDR_W - $clog2(UNIT_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [TAG_W-1:0]  start_tag_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DST_W-1:0]  dst_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_req_o,
  output logic              rd_first_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              dst_we_o,
  output logic [DST_W-1:0]  dst_addr_o,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              free_vld_o,
  output logic [TAG_W-1:0]  free_tag_o
);
  logic load, new_unit, word_vld;

  cce_walker #(
    .DATA_W(DATA_W), .UNIT_WORDS(UNIT_WORDS), .TAG_W(TAG_W), .LEN_W(LEN_W)
  ) u_walker (
    .clk_i, .rst_ni, .go_i, .start_tag_i, .len_i,
    .load_o(load), .new_unit_o(new_unit), .busy_o, .done_o,
    .rd_req_o, .rd_addr_o, .rd_gnt_i, .rd_data_i,
    .word_vld_o(word_vld), .free_vld_o, .free_tag_o
  );

  cce_burst u_burst (
    .clk_i, .rst_ni, .new_unit_i(new_unit),
    .req_i(rd_req_o), .gnt_i(rd_gnt_i), .first_o(rd_first_o)
  );

  cce_sink #(.DATA_W(DATA_W), .DST_W(DST_W)) u_sink (
    .clk_i, .rst_ni, .load_i(load), .base_i(dst_base_i),
    .word_vld_i(word_vld), .word_i(rd_data_i),
    .we_o(dst_we_o), .addr_o(dst_addr_o), .data_o(dst_data_o)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o && !dst_we_o && !free_vld_o);
endmodule

// File: tb/tb_chain_copy_engine.sv
module tb_chain_copy_engine;
  typedef struct packed {
    logic [4:0]  tag;
    logic [11:0] len;
    logic [11:0] base;
    logic [1:0]  mode;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{5'd2,  12'd1,  12'd100, 2'd0},
    '{5'd5,  12'd14, 12'd200, 2'd0},
    '{5'd9,  12'd15, 12'd300, 2'd0},
    '{5'd30, 12'd60, 12'd400, 2'd0},
    '{5'd0,  12'd40, 12'd500, 2'd1},
    '{5'd17, 12'd29, 12'd600, 2'd2}
  };

  logic clk_i = 0, rst_ni = 0, go_i = 0, rd_gnt_i = 1;
  logic [4:0] start_tag_i = 0;
  logic [11:0] len_i = 0, dst_base_i = 0;
  logic busy_o, done_o, rd_req_o, rd_first_o, dst_we_o, free_vld_o;
  logic [7:0] rd_addr_o;
  logic [15:0] rd_data_i = 0, dst_data_o;
  logic [11:0] dst_addr_o;
  logic [4:0] free_tag_o;

  chain_copy_engine dut (.*);

  always #4 clk_i = ~clk_i;

  logic [15:0] mem [256];
  int cyc = 0, mode = 0, checks = 0, errors = 0;
  int rd_n, lnk_n, first_n, burst_bad, wr_n, free_n, done_n, done_cyc, wlast, flast;
  bit busy_at_done, refused_q;
  int wr_addr [64];
  int wr_data [64];
  int free_log [16];

  function automatic logic [15:0] pat(int t, int i);
    return 16'((t * 1109 + i * 73 + 689) ^ 16'h5a5a);
  endfunction

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    refused_q <= rd_req_o && !rd_gnt_i;
    if (rd_req_o && rd_gnt_i) begin
      rd_n <= rd_n + 1;
      if (rd_addr_o[2:0] == 3'd7) lnk_n <= lnk_n + 1;
      if (rd_first_o) first_n <= first_n + 1;
      if (refused_q && !rd_first_o) burst_bad <= burst_bad + 1;
      rd_data_i <= mem[rd_addr_o];
    end
    if (dst_we_o) begin
      if (wr_n < 64) begin
        wr_addr[wr_n] <= int'(dst_addr_o);
        wr_data[wr_n] <= int'(dst_data_o);
      end
      wr_n  <= wr_n + 1;
      wlast <= cyc;
    end
    if (free_vld_o) begin
      if (free_n < 16) free_log[free_n] <= int'(free_tag_o);
      free_n <= free_n + 1;
      flast  <= cyc;
    end
    if (done_o) begin
      done_n <= done_n + 1;
      done_cyc <= cyc;
      busy_at_done <= busy_o;
    end
  end

  always @(negedge clk_i) begin
    case (mode)
      1:       rd_gnt_i <= (cyc % 3) != 0;
      2:       rd_gnt_i <= (cyc % 4) < 2;
      default: rd_gnt_i <= 1'b1;
    endcase
  end

  initial begin
    #1500000;
    errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    rd_n = 0; lnk_n = 0; first_n = 0; burst_bad = 0; wr_n = 0;
    free_n = 0; done_n = 0; done_cyc = -1; wlast = -1; flast = -1;
  endtask

  task automatic kick(int t, int l, int b);
    @(negedge clk_i);
    start_tag_i = 5'(t); len_i = 12'(l); dst_base_i = 12'(b); go_i = 1;
    @(negedge clk_i);
    go_i = 0;
  endtask

  task automatic finish_check(int t, int l, int b, int md);
    int words, units, tmo, bad, exp_last;
    tmo = 0;
    while (done_n == 0 && tmo < 3000) begin
      @(negedge clk_i);
      tmo++;
    end
    repeat (4) @(negedge clk_i);
    words = (l + 1) / 2;
    units = (words == 0) ? 1 : (words + 6) / 7;
    chk(done_n == 1, "R9", "done pulses", done_n, 1);
    chk(wr_n == words, "R3", "write count", wr_n, words);
    bad = 0;
    for (int w = 0; w < words && w < 64; w++) begin
      int et;
      et = (t + 7 * (w / 7)) % 32;
      if (wr_addr[w] != ((b + w) % 4096) || wr_data[w] != int'(pat(et, w % 7))) begin
        bad++;
        if (bad == 1)
          $display("FAIL R3 word %0d addr act=%0d exp=%0d data act=%0h exp=%0h",
                   w, wr_addr[w], b + w, wr_data[w], pat(et, w % 7));
      end
    end
    chk(bad == 0, "R3", "mismatched words", bad, 0);
    chk(free_n == units, "R5", "freed tags", free_n, units);
    bad = 0;
    for (int u = 0; u < units && u < 16; u++)
      if (free_log[u] != (t + 7 * u) % 32) bad++;
    chk(bad == 0, "R5", "tag order mismatches", bad, 0);
    chk(lnk_n == units - 1, "R4", "link reads", lnk_n, units - 1);
    chk(rd_n == ((words == 0) ? 0 : words + units - 1), "R6", "granted reads",
        rd_n, (words == 0) ? 0 : words + units - 1);
    exp_last = (wlast > flast) ? wlast : flast;
    chk(done_cyc == exp_last + 1, "R9", "done cycle", done_cyc, exp_last + 1);
    chk(!busy_at_done, "R9", "busy at done", int'(busy_at_done), 0);
    if (md == 0 && words != 0)
      chk(first_n == units, "R8", "burst starts", first_n, units);
    else
      chk(burst_bad == 0, "R8", "unmarked read after refusal R7", burst_bad, 0);
  endtask

  initial begin
    for (int t = 0; t < 32; t++) begin
      for (int i = 0; i < 7; i++) mem[t * 8 + i] = pat(t, i);
      mem[t * 8 + 7] = 16'hA0E0 | 16'((t + 7) % 32);
    end
    clear_logs();
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !rd_req_o && !rd_first_o && !dst_we_o && !free_vld_o,
        "R1", "outputs in reset", int'(busy_o | rd_req_o | dst_we_o | free_vld_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !rd_req_o, "R1", "idle after reset", int'(busy_o), 0);

    for (int v = 0; v < NV; v++) begin
      clear_logs();
      mode = int'(VECS[v].mode);
      kick(int'(VECS[v].tag), int'(VECS[v].len), int'(VECS[v].base));
      chk(busy_o == 1'b1, "R2", "busy after go", int'(busy_o), 1);
      finish_check(int'(VECS[v].tag), int'(VECS[v].len), int'(VECS[v].base), mode);
    end

    // R10: second go mid-transfer must be ignored
    clear_logs();
    mode = 0;
    kick(12, 20, 300);
    repeat (3) @(negedge clk_i);
    kick(3, 2, 900);
    finish_check(12, 20, 300, 0);
    repeat (20) @(negedge clk_i);
    chk(done_n == 1 && !busy_o, "R10", "extra transfer after ignored go", done_n, 1);

    // R11: zero length
    clear_logs();
    kick(21, 0, 50);
    finish_check(21, 0, 50, 0);
    chk(free_n >= 1 && free_log[0] == 21, "R11", "start tag freed", free_log[0], 21);
    chk(rd_n == 0 && wr_n == 0, "R11", "reads plus writes", rd_n + wr_n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule